// File: doc/BRIEF.md
# Gene Crossover and Mutation Lane

This block is one lane of a pipelined datapath for evolutionary search. Every clock cycle it takes one gene from each of two parents and produces one child gene. A gene sits in a 16-bit slot. Bits [10:0] hold an 11-bit value and bits [12:11] hold two control bits that travel with the gene. Bits [15:13] carry nothing.

Six per-gene select inputs decide what happens to each gene. They pick the parent, choose uniform or bell-shaped random numbers, scale the new value, substitute a constant, choose between adding and replacing, and gate the mutation as a whole. Three quasi-static parameters set the scale factors and the constant: a random ceiling, a constant and a fraction. Both are applied as value/1024. Two linear-feedback random sources sit inside the lane.

A valid flag travels with each gene through three register stages: parent pick, new-value generation, and combine. A single ready input freezes all three stages together. The upstream logic holds the quasi-static parameters steady while genes that use them are in flight; they are read at the second stage.

Top module: `gene_xm_lane`

## Requirements
- R1: While `rst_n` is low, `out_valid` and `child` are 0, and any genes in flight are discarded.
- R2: `child` bits [10:0] hold the value, and bits [12:11] hold the control bits of the parent selected by `sel_parent`. Bits [15:13] are always 0, whatever the input slots carry there.
- R3: `sel_parent`=0 takes the mother slot and 1 takes the father slot. With `sel_mutate`=0 the selected value passes through unchanged, whatever the other selects are.
- R4: A gene accepted at a rising edge with `in_valid`=1 and `out_ready`=1 appears on `child` with `out_valid`=1 after the third enabled edge. The lane accepts one gene per cycle, and `out_valid` follows `in_valid` with this latency.
- R5: While `out_ready` is 0, all stages hold, `child` and `out_valid` are stable, and `in_valid` and the input data are ignored.
- R6: With `sel_const`=1, `sel_scale`=0, `sel_replace`=1 and `sel_mutate`=1, the child value equals `const_val`.
- R7: With `sel_const`=1 and `sel_scale`=1, the new value is floor(`const_val`*`fraction`/1024), clamped at 2047.
- R8: With `sel_replace`=0 and `sel_mutate`=1, the child value is the parent value plus the new value, saturating at 2047.
- R9: With `sel_const`=0 and `sel_scale`=1, the new value is floor(r*`rand_max`/1024), where r is an 11-bit random value. It never exceeds floor(2047*`rand_max`/1024) and is 0 when `rand_max` is 0.
- R10: With `sel_gauss`=0 and `sel_scale`=0, the random new value is uniform over 0..2047 and varies from gene to gene.
- R11: With `sel_gauss`=1, the random value is the mean of four uniform 11-bit samples. Its average lies near 1023, and at most a quarter of the samples fall outside 512..1535.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Parent genes present this cycle |
| mother | input | 16 | Mother gene slot |
| father | input | 16 | Father gene slot |
| sel_parent | input | 1 | 0 mother, 1 father |
| sel_gauss | input | 1 | 0 uniform, 1 bell-shaped random |
| sel_scale | input | 1 | Scale the new value |
| sel_const | input | 1 | 0 random, 1 constant as new value |
| sel_replace | input | 1 | 0 add to parent value, 1 replace it |
| sel_mutate | input | 1 | 0 pass parent value, 1 use mutated value |
| rand_max | input | 11 | Random scale factor (/1024) |
| const_val | input | 11 | Constant new value |
| fraction | input | 11 | Constant scale factor (/1024) |
| out_ready | input | 1 | Advance the pipeline; 0 stalls every stage |
| out_valid | output | 1 | `child` holds a gene |
| child | output | 16 | Child gene slot |

## Verification
The bound checker watches four properties on every cycle:
- the empty top bits of the child slot;
- the three-cycle valid latency under continuous ready;
- the frozen output during a stall;
- at the combine stage, that pass-through copies the parent value and that an additive mutation never lands below it.

Exact arithmetic can only be shown by the bench's vectors: constant substitution, fraction scaling with its clamp, and the saturation edge at 2047. The same holds for the ignored inputs during a stall and the flush on reset. The statistics of the two random sources can only be judged over many genes: spread for uniform, centring and tail weight for bell-shaped, and the ceiling under a random scale factor.

// File: rtl/gxm_pkg.sv
package gxm_pkg;

    // Per-gene operation selects, one bit each
    typedef struct packed {
        logic parent;   // 0 mother, 1 father
        logic gauss;    // 0 uniform, 1 bell-shaped
        logic scale;    // apply value/1024 factor
        logic konst;    // new value from constant
        logic replace;  // 0 add, 1 replace
        logic mutate;   // 0 pass parent value
    } sel_t;

endpackage

// File: rtl/gxm_lfsr.sv
module gxm_lfsr #(
    parameter int             W     = 32,
    parameter logic [W-1:0]   TAPS  = 32'h8020_0003,
    parameter logic [W-1:0]   SEED  = 32'h1ACE_B00C,
    parameter int             STEP  = 11
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    output logic [W-1:0] state_o
);

    logic [W-1:0] state_d, state_q;

    function automatic logic [W-1:0] advance(input logic [W-1:0] s);
        logic [W-1:0] t;
        t = s;
        for (int i = 0; i < STEP; i++) begin
            t = {t[W-2:0], ^(t & TAPS)};
        end
        return t;
    endfunction

    always_comb begin
        state_d = state_q;
        if (en) begin
            state_d = advance(state_q);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SEED;
        end else begin
            state_q <= state_d;
        end
    end

    assign state_o = state_q;

endmodule

// File: rtl/gxm_rand_src.sv
module gxm_rand_src #(
    parameter int  GENE_W   = 11,
    parameter int  UNI_W    = 32,
    parameter int  GAUSS_N  = 4,
    parameter logic [UNI_W-1:0]          UNI_TAPS  = 32'h8020_0003,
    parameter logic [UNI_W-1:0]          UNI_SEED  = 32'h1ACE_B00C,
    parameter logic [GAUSS_N*GENE_W-1:0] GS_TAPS   = 44'hC00_0003_0000,
    parameter logic [GAUSS_N*GENE_W-1:0] GS_SEED   = 44'h7E5_7C0D_E123
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    output logic [GENE_W-1:0] uni_o,
    output logic [GENE_W-1:0] gauss_o
);

    localparam int GS_W  = GAUSS_N * GENE_W;
    localparam int LOG_N = $clog2(GAUSS_N);
    localparam int SUM_W = GENE_W + LOG_N;

    logic [UNI_W-1:0] uni_state;
    logic [GS_W-1:0]  gs_state;

    gxm_lfsr #(.W(UNI_W), .TAPS(UNI_TAPS), .SEED(UNI_SEED), .STEP(GENE_W)) u_uni (
        .clk(clk), .rst_n(rst_n), .en(en), .state_o(uni_state)
    );

    gxm_lfsr #(.W(GS_W), .TAPS(GS_TAPS), .SEED(GS_SEED), .STEP(GS_W)) u_gs (
        .clk(clk), .rst_n(rst_n), .en(en), .state_o(gs_state)
    );

    // Running sum of GAUSS_N disjoint uniform slices
    logic [SUM_W-1:0] part [GAUSS_N+1];
    assign part[0] = '0;

    for (genvar i = 0; i < GAUSS_N; i++) begin : g_sum
        assign part[i+1] = part[i] + SUM_W'(gs_state[i*GENE_W +: GENE_W]);
    end

    // Mean of the slices recentres the sum onto the gene range
    assign gauss_o = part[GAUSS_N][SUM_W-1 -: GENE_W];
    assign uni_o   = uni_state[UNI_W-1 -: GENE_W];

endmodule

// File: rtl/gxm_value_gen.sv
module gxm_value_gen #(
    parameter int GENE_W   = 11,
    parameter int SCALE_SH = 10
) (
    input  logic [GENE_W-1:0] rnd,
    input  logic              scale,
    input  logic              konst,
    input  logic [GENE_W-1:0] rand_max,
    input  logic [GENE_W-1:0] const_val,
    input  logic [GENE_W-1:0] fraction,
    output logic [GENE_W-1:0] nval
);

    localparam int PROD_W = 2 * GENE_W;

    logic [GENE_W-1:0] base, factor;
    logic [PROD_W-1:0] prod, shifted;

    always_comb begin
        base    = konst ? const_val : rnd;
        factor  = konst ? fraction  : rand_max;
        prod    = PROD_W'(base) * PROD_W'(factor);
        shifted = prod >> SCALE_SH;
        if (!scale) begin
            nval = base;
        end else if (|shifted[PROD_W-1:GENE_W]) begin
            nval = '1;
        end else begin
            nval = shifted[GENE_W-1:0];
        end
    end

endmodule

// File: rtl/gxm_combine.sv
module gxm_combine #(
    parameter int GENE_W = 11
) (
    input  logic [GENE_W-1:0] orig,
    input  logic [GENE_W-1:0] nval,
    input  logic              replace,
    input  logic              mutate,
    output logic [GENE_W-1:0] val
);

    logic [GENE_W:0]   sum;
    logic [GENE_W-1:0] sat, mval;

    always_comb begin
        sum  = {1'b0, orig} + {1'b0, nval};
        sat  = sum[GENE_W] ? '1 : sum[GENE_W-1:0];
        mval = replace ? nval : sat;
        val  = mutate ? mval : orig;
    end

endmodule

// File: rtl/gene_xm_lane.sv
module gene_xm_lane
    import gxm_pkg::*;
#(
    parameter int GENE_W   = 11,
    parameter int CTRL_W   = 2,
    parameter int SLOT_W   = 16,
    parameter int SCALE_SH = 10,
    parameter int UNI_W    = 32,
    parameter int GAUSS_N  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [SLOT_W-1:0] mother,
    input  logic [SLOT_W-1:0] father,
    input  logic              sel_parent,
    input  logic              sel_gauss,
    input  logic              sel_scale,
    input  logic              sel_const,
    input  logic              sel_replace,
    input  logic              sel_mutate,
    input  logic [GENE_W-1:0] rand_max,
    input  logic [GENE_W-1:0] const_val,
    input  logic [GENE_W-1:0] fraction,
    input  logic              out_ready,
    output logic              out_valid,
    output logic [SLOT_W-1:0] child
);

    localparam int PAD_W = SLOT_W - GENE_W - CTRL_W;

    typedef struct packed {
        logic              vld;
        logic [CTRL_W-1:0] ctrl;
        logic [GENE_W-1:0] orig;
        logic [GENE_W-1:0] rnd;
        logic              scale;
        logic              konst;
        logic              replace;
        logic              mutate;
    } s1_t;

    typedef struct packed {
        logic              vld;
        logic [CTRL_W-1:0] ctrl;
        logic [GENE_W-1:0] orig;
        logic [GENE_W-1:0] nval;
        logic              replace;
        logic              mutate;
    } s2_t;

    typedef struct packed {
        logic              vld;
        logic [SLOT_W-1:0] slot;
    } s3_t;

    typedef struct packed {
        s1_t s1;
        s2_t s2;
        s3_t s3;
    } pipe_t;

    pipe_t pipe_d, pipe_q;

    sel_t              sel_in;
    logic [SLOT_W-1:0] picked;
    logic [GENE_W-1:0] uni_val, gauss_val, new_val, comb_val;

    assign sel_in = '{parent:  sel_parent,  gauss:   sel_gauss,
                      scale:   sel_scale,   konst:   sel_const,
                      replace: sel_replace, mutate:  sel_mutate};

    gxm_rand_src #(.GENE_W(GENE_W), .UNI_W(UNI_W), .GAUSS_N(GAUSS_N)) u_rng (
        .clk(clk), .rst_n(rst_n), .en(out_ready),
        .uni_o(uni_val), .gauss_o(gauss_val)
    );

    gxm_value_gen #(.GENE_W(GENE_W), .SCALE_SH(SCALE_SH)) u_gen (
        .rnd(pipe_q.s1.rnd), .scale(pipe_q.s1.scale), .konst(pipe_q.s1.konst),
        .rand_max(rand_max), .const_val(const_val), .fraction(fraction),
        .nval(new_val)
    );

    gxm_combine #(.GENE_W(GENE_W)) u_comb (
        .orig(pipe_q.s2.orig), .nval(pipe_q.s2.nval),
        .replace(pipe_q.s2.replace), .mutate(pipe_q.s2.mutate),
        .val(comb_val)
    );

    assign picked = sel_in.parent ? father : mother;

    always_comb begin
        pipe_d = pipe_q;
        if (out_ready) begin
            // stage 1: crossover pick and random source
            pipe_d.s1.vld     = in_valid;
            pipe_d.s1.ctrl    = picked[GENE_W +: CTRL_W];
            pipe_d.s1.orig    = picked[GENE_W-1:0];
            pipe_d.s1.rnd     = sel_in.gauss ? gauss_val : uni_val;
            pipe_d.s1.scale   = sel_in.scale;
            pipe_d.s1.konst   = sel_in.konst;
            pipe_d.s1.replace = sel_in.replace;
            pipe_d.s1.mutate  = sel_in.mutate;
            // stage 2: new value
            pipe_d.s2.vld     = pipe_q.s1.vld;
            pipe_d.s2.ctrl    = pipe_q.s1.ctrl;
            pipe_d.s2.orig    = pipe_q.s1.orig;
            pipe_d.s2.nval    = new_val;
            pipe_d.s2.replace = pipe_q.s1.replace;
            pipe_d.s2.mutate  = pipe_q.s1.mutate;
            // stage 3: combine and repack
            pipe_d.s3.vld     = pipe_q.s2.vld;
            pipe_d.s3.slot    = {{PAD_W{1'b0}}, pipe_q.s2.ctrl, comb_val};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign out_valid = pipe_q.s3.vld;
    assign child     = pipe_q.s3.slot;

endmodule

// File: rtl/gxm_lane_chk.sv
module gxm_lane_chk #(
    parameter int GENE_W = 11,
    parameter int CTRL_W = 2,
    parameter int SLOT_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              out_ready,
    input logic              out_valid,
    input logic [SLOT_W-1:0] child,
    input logic              s2_vld,
    input logic              s2_mut,
    input logic              s2_rep,
    input logic [GENE_W-1:0] s2_orig
);

    logic [1:0] age;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            age <= '0;
        end else if (age != 2'd3) begin
            age <= age + 2'd1;
        end
    end

    p_pad_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> child[SLOT_W-1:GENE_W+CTRL_W] == '0);

    p_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2'd3 && $past(out_ready) && $past(out_ready, 2) && $past(out_ready, 3))
        |-> out_valid == $past(in_valid, 3));

    p_stall_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !out_ready |=> ($stable(child) && $stable(out_valid)));

    p_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (s2_vld && !s2_mut && out_ready) |=> child[GENE_W-1:0] == $past(s2_orig));

    p_add_floor_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (s2_vld && s2_mut && !s2_rep && out_ready) |=> child[GENE_W-1:0] >= $past(s2_orig));

endmodule

bind gene_xm_lane gxm_lane_chk #(.GENE_W(GENE_W), .CTRL_W(CTRL_W), .SLOT_W(SLOT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_ready(out_ready),
    .out_valid(out_valid), .child(child),
    .s2_vld(pipe_q.s2.vld), .s2_mut(pipe_q.s2.mutate),
    .s2_rep(pipe_q.s2.replace), .s2_orig(pipe_q.s2.orig)
);

// File: tb/sim_gene_xm_lane.sv
module sim_gene_xm_lane;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] mother = '0, father = '0;
    logic [5:0]  sel = '0;   // {parent,gauss,scale,const,replace,mutate}
    logic [10:0] rand_max = '0, const_val = '0, fraction = '0;
    logic        out_ready = 1'b1;
    logic        out_valid;
    logic [15:0] child;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    gene_xm_lane u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .mother(mother), .father(father),
        .sel_parent(sel[5]), .sel_gauss(sel[4]), .sel_scale(sel[3]),
        .sel_const(sel[2]), .sel_replace(sel[1]), .sel_mutate(sel[0]),
        .rand_max(rand_max), .const_val(const_val), .fraction(fraction),
        .out_ready(out_ready), .out_valid(out_valid), .child(child)
    );

    typedef struct packed {
        logic [15:0] mom;
        logic [15:0] dad;
        logic [5:0]  sel;
        logic [10:0] mx;
        logic [10:0] kv;
        logic [10:0] fr;
        logic [10:0] ev;
        logic [1:0]  ec;
        logic [15:0] tag;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VEC [NV] = '{
        '{16'h0864, 16'h15DC, 6'b000000, 11'd0,   11'd0,    11'd0,    11'd100,  2'b01, "R3"},
        '{16'h0864, 16'h15DC, 6'b100000, 11'd0,   11'd0,    11'd0,    11'd1500, 2'b10, "R2"},
        '{16'h0864, 16'h15DC, 6'b000111, 11'd0,   11'd777,  11'd0,    11'd777,  2'b01, "R6"},
        '{16'h0864, 16'h15DC, 6'b100110, 11'd0,   11'd777,  11'd0,    11'd1500, 2'b10, "R3"},
        '{16'h0864, 16'h15DC, 6'b101111, 11'd0,   11'd1024, 11'd512,  11'd512,  2'b10, "R7"},
        '{16'h0864, 16'h15DC, 6'b001111, 11'd0,   11'd1000, 11'd1023, 11'd999,  2'b01, "R7"},
        '{16'h0864, 16'h15DC, 6'b001111, 11'd0,   11'd2000, 11'd2047, 11'd2047, 2'b01, "R7"},
        '{16'h0864, 16'h15DC, 6'b001111, 11'd0,   11'd500,  11'd0,    11'd0,    2'b01, "R7"},
        '{16'h0864, 16'h15DC, 6'b000111, 11'd0,   11'd333,  11'd0,    11'd333,  2'b01, "R6"},
        '{16'h0864, 16'h15DC, 6'b000101, 11'd0,   11'd200,  11'd0,    11'd300,  2'b01, "R8"},
        '{16'h0864, 16'h15DC, 6'b100101, 11'd0,   11'd1000, 11'd0,    11'd2047, 2'b10, "R8"},
        '{16'h0864, 16'h15DC, 6'b100101, 11'd0,   11'd547,  11'd0,    11'd2047, 2'b10, "R8"},
        '{16'h0864, 16'h15DC, 6'b100101, 11'd0,   11'd546,  11'd0,    11'd2046, 2'b10, "R8"},
        '{16'h1FFF, 16'h15DC, 6'b000101, 11'd0,   11'd0,    11'd0,    11'd2047, 2'b11, "R8"},
        '{16'h0864, 16'h15DC, 6'b001011, 11'd0,   11'd0,    11'd0,    11'd0,    2'b01, "R9"},
        '{16'h0864, 16'h15DC, 6'b011011, 11'd0,   11'd0,    11'd0,    11'd0,    2'b01, "R9"},
        '{16'h0864, 16'h15DC, 6'b001001, 11'd0,   11'd0,    11'd0,    11'd100,  2'b01, "R9"},
        '{16'h0864, 16'h0000, 6'b100000, 11'd0,   11'd0,    11'd0,    11'd0,    2'b00, "R2"},
        '{16'hE864, 16'hF5DC, 6'b000000, 11'd0,   11'd0,    11'd0,    11'd100,  2'b01, "R2"}
    };

    task automatic chk(input bit ok, input logic [15:0] tag,
                       input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Send one gene and return the slot after the third edge
    task automatic run_one(input logic [15:0] m, input logic [15:0] f,
                           input logic [5:0] s, output logic [15:0] res,
                           output logic vld);
        @(negedge clk);
        mother = m; father = f; sel = s; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        res = child;
        vld = out_valid;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [15:0] r;
        logic        v;
        int          cnt, sum, outside;
        bit          seen [2048];

        // R1: reset state
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0 && child == 16'h0, "R1", child, 16'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // Vector table walk
        for (int i = 0; i < NV; i++) begin
            rand_max = VEC[i].mx; const_val = VEC[i].kv; fraction = VEC[i].fr;
            run_one(VEC[i].mom, VEC[i].dad, VEC[i].sel, r, v);
            chk(v && r == {3'b000, VEC[i].ec, VEC[i].ev}, VEC[i].tag,
                r, {3'b000, VEC[i].ec, VEC[i].ev});
        end

        // R4: latency and back-to-back throughput
        sel = 6'b000000;
        @(negedge clk); mother = 16'h0011; in_valid = 1'b1;
        @(negedge clk); mother = 16'h0022;
        @(negedge clk); mother = 16'h0033;
        chk(out_valid == 1'b0, "R4", {15'b0, out_valid}, 16'h0);
        @(negedge clk); in_valid = 1'b0;
        chk(out_valid && child == 16'h0011, "R4", child, 16'h0011);
        @(negedge clk);
        chk(out_valid && child == 16'h0022, "R4", child, 16'h0022);
        @(negedge clk);
        chk(out_valid && child == 16'h0033, "R4", child, 16'h0033);
        @(negedge clk);
        chk(out_valid == 1'b0, "R4", {15'b0, out_valid}, 16'h0);

        // R5: stall freezes everything, inputs ignored
        @(negedge clk); mother = 16'h0101; in_valid = 1'b1;
        @(negedge clk); mother = 16'h0202;
        @(negedge clk); in_valid = 1'b0;
        @(negedge clk);
        chk(out_valid && child == 16'h0101, "R5", child, 16'h0101);
        out_ready = 1'b0; mother = 16'h0303; in_valid = 1'b1;
        repeat (4) @(negedge clk);
        chk(out_valid && child == 16'h0101, "R5", child, 16'h0101);
        out_ready = 1'b1; in_valid = 1'b0;
        @(negedge clk);
        chk(out_valid && child == 16'h0202, "R5", child, 16'h0202);
        @(negedge clk);
        chk(out_valid == 1'b0, "R5", {15'b0, out_valid}, 16'h0);
        @(negedge clk);
        chk(out_valid == 1'b0, "R5", {15'b0, out_valid}, 16'h0);

        // R1: reset discards an in-flight gene
        @(negedge clk); mother = 16'h0444; in_valid = 1'b1;
        @(negedge clk); in_valid = 1'b0; rst_n = 1'b0;
        #1;
        chk(out_valid == 1'b0 && child == 16'h0, "R1", child, 16'h0);
        @(negedge clk); rst_n = 1'b1;
        cnt = 0;
        repeat (4) begin
            @(negedge clk);
            if (out_valid) cnt++;
        end
        chk(cnt == 0, "R1", cnt[15:0], 16'h0);

        // R10: uniform spread
        cnt = 0;
        for (int i = 0; i < 2048; i++) seen[i] = 1'b0;
        for (int i = 0; i < 32; i++) begin
            run_one(16'h0000, 16'h0000, 6'b000011, r, v);
            if (!seen[r[10:0]]) cnt++;
            seen[r[10:0]] = 1'b1;
        end
        chk(cnt >= 24, "R10", cnt[15:0], 16'd24);

        // R9: random scaled by rand_max=256 stays within 511
        rand_max = 11'd256;
        cnt = 0;
        for (int i = 0; i < 32; i++) begin
            run_one(16'h0000, 16'h0000, 6'b001011, r, v);
            if (r[10:0] > 11'd511) cnt++;
        end
        chk(cnt == 0, "R9", cnt[15:0], 16'h0);

        // R11: bell-shaped source centring and tails
        sum = 0; outside = 0;
        for (int i = 0; i < 64; i++) begin
            run_one(16'h0000, 16'h0000, 6'b010011, r, v);
            sum += int'(r[10:0]);
            if (r[10:0] < 11'd512 || r[10:0] > 11'd1535) outside++;
        end
        chk(sum / 64 >= 823 && sum / 64 <= 1223, "R11", 16'(sum / 64), 16'd1023);
        chk(outside <= 16, "R11", outside[15:0], 16'd16);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule